// File: doc/BRIEF.md
# Serial Command Word Receiver

This block takes 24-bit command words from a write-only, three-wire serial link (clock, data, active-low select) and turns each finished word into a single-cycle write request for a 16-entry channel code memory. The serial clock, select and data lines are brought into the system clock domain through synchronisers. Serial clock edges are detected in that domain, so the serial clock must run several times slower than the system clock.

A word carries a 16-bit channel code, a 4-bit channel number and two mode bits. When the last bit arrives, the block issues one write pulse with the address and data. In the same cycle it latches the two mode bits. Each latched bit is ORed with an external pin, and the two results drive the refresh sequencer: immediate-versus-burst update, and external-versus-internal sequencer clock. Any number of whole words may be sent in one select frame. A trailing partial word is dropped. The synchronised select level is also given to the sequencer as a hold request, and a separate input blocks all serial traffic while a reset sequence runs.

Top module: `spi_cmd_rx`

## Requirements
- R1: Bits are taken MSB first on serial clock rising edges. In arrival order a word is: code bit 15 down to bit 0, channel bits 3 down to 0, a reserved bit, the immediate bit, the clock-select bit, and a trailing fill bit.
- R2: Each completed word produces exactly one `wr_en` pulse, one system clock wide. `wr_addr` and `wr_data` hold the word's channel and code during that pulse.
- R3: Several whole words sent back to back in one select frame each produce their own write, in order.
- R4: If select rises before a word is complete, the partial word is discarded and no write is issued.
- R5: The bit position restarts at zero on every new frame, so the first rising serial clock edge after select falls always supplies code bit 15.
- R6: `mode_immed` is the latched immediate bit OR `pin_immed`. `mode_extclk` is the latched clock-select bit OR `pin_extclk`. The latched bits change only when a word completes.
- R7: While `rst_seq_busy` is high, serial input is ignored: no write occurs and the latched mode bits keep their values.
- R8: `seq_hold` is high while the synchronised select is low and low otherwise.
- R9: On each completed word, `rsvd_err` is set to 1 if the reserved bit or the fill bit is 1, and cleared to 0 if both are 0.
- R10: After reset `wr_en`, both latched mode bits, `rsvd_err` and `seq_hold` are 0.
- R11: Serial clock edges seen while select is high neither shift data nor count bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_sel_n | input | 1 | Active-low frame select, asynchronous |
| ser_dat | input | 1 | Serial data, asynchronous |
| rst_seq_busy | input | 1 | High while a reset sequence runs; serial input is ignored |
| pin_immed | input | 1 | External immediate-update request |
| pin_extclk | input | 1 | External sequencer clock select |
| wr_en | output | 1 | One-cycle memory write strobe |
| wr_addr | output | 4 | Channel number for the write |
| wr_data | output | 16 | Channel code for the write |
| mode_immed | output | 1 | Effective immediate-update mode |
| mode_extclk | output | 1 | Effective external sequencer clock mode |
| seq_hold | output | 1 | Hold request to the sequencer (select active) |
| rsvd_err | output | 1 | Last word had a nonzero reserved or fill bit |

## Verification
The bench looks for framing faults. A receiver that counted serial clock pulses while deselected, or failed to restart its count on a new frame, would fire its write early with data shifted by the stray bits. One that fired on a truncated frame would write a bogus channel. Back-to-back words in one frame catch a counter that does not wrap and so writes only once. Mode dominance is checked both ways: a pin alone, and a latched bit alone. The reset-busy window is checked for writes and for mode bits that leak through. A receiver that tested the reserved bits at the wrong positions would mis-report `rsvd_err`.

// File: rtl/spi_cmd_rx_pkg.sv
package spi_cmd_rx_pkg;
  localparam int WORD_W   = 24;
  localparam int DATA_W   = 16;
  localparam int ADDR_W   = 4;
  localparam int CNT_W    = $clog2(WORD_W);
  // bit positions inside the assembled word, bit 0 arriving last
  localparam int POS_FILL = 0;
  localparam int POS_CSEL = 1;
  localparam int POS_IMM  = 2;
  localparam int POS_RSV  = 3;
  localparam int ADDR_LO  = WORD_W - DATA_W - ADDR_W;
  localparam int DATA_LO  = WORD_W - DATA_W;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);
endpackage

// File: rtl/spi_cmd_rx_sync.sv
module spi_cmd_rx_sync #(
  parameter int          WIDTH   = 1,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= d_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q_out = stg[STAGES-1];
endmodule

// File: rtl/spi_cmd_rx_shift.sv
module spi_cmd_rx_shift
  import spi_cmd_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              seln_s,
  input  logic              dat_s,
  input  logic              blocked,
  output logic              word_done,
  output logic [WORD_W-1:0] word_full,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  logic              sclk_d;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [WORD_W-2:0] sr_q, sr_n;
  logic              wr_q, wr_n;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              rise, active;

  assign rise      = sclk_s & ~sclk_d;
  assign active    = ~seln_s & ~blocked;
  assign word_full = {sr_q, dat_s};
  assign word_done = rise & active & (cnt_q == LAST_BIT);

  always_comb begin
    cnt_n = cnt_q;
    sr_n  = sr_q;
    if (!active) begin
      cnt_n = '0;
    end else if (rise) begin
      sr_n  = {sr_q[WORD_W-3:0], dat_s};
      cnt_n = (cnt_q == LAST_BIT) ? '0 : cnt_q + 1'b1;
    end
    wr_n = word_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      cnt_q  <= '0;
      sr_q   <= '0;
      wr_q   <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      cnt_q  <= cnt_n;
      sr_q   <= sr_n;
      wr_q   <= wr_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (word_done) begin
      addr_q <= word_full[ADDR_LO +: ADDR_W];
      data_q <= word_full[DATA_LO +: DATA_W];
    end
  end

  assign wr_en   = wr_q;
  assign wr_addr = addr_q;
  assign wr_data = data_q;

  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_BIT);
  assert_strobe_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  assert_wr_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(!seln_s));
  assert_cnt_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    seln_s |=> (cnt_q == '0));
  assert_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(blocked) |-> !wr_en);
endmodule

// File: rtl/spi_cmd_rx_mode.sv
module spi_cmd_rx_mode (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic bit_imm,
  input  logic bit_csel,
  input  logic bit_rsv,
  input  logic bit_fill,
  input  logic pin_immed,
  input  logic pin_extclk,
  output logic mode_immed,
  output logic mode_extclk,
  output logic rsvd_err
);
  logic imm_q, csel_q, err_q;
  logic imm_n, csel_n, err_n;

  always_comb begin
    imm_n  = imm_q;
    csel_n = csel_q;
    err_n  = err_q;
    if (load) begin
      imm_n  = bit_imm;
      csel_n = bit_csel;
      err_n  = bit_rsv | bit_fill;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imm_q  <= 1'b0;
      csel_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      imm_q  <= imm_n;
      csel_q <= csel_n;
      err_q  <= err_n;
    end
  end

  assign mode_immed  = imm_q | pin_immed;
  assign mode_extclk = csel_q | pin_extclk;
  assign rsvd_err    = err_q;

  assert_pin_imm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pin_immed |-> mode_immed);
  assert_pin_csel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pin_extclk |-> mode_extclk);
  assert_latch_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(imm_q) && $stable(csel_q)));
endmodule

// File: rtl/spi_cmd_rx.sv
module spi_cmd_rx
  import spi_cmd_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_sel_n,
  input  logic              ser_dat,
  input  logic              rst_seq_busy,
  input  logic              pin_immed,
  input  logic              pin_extclk,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              mode_immed,
  output logic              mode_extclk,
  output logic              seq_hold,
  output logic              rsvd_err
);
  logic [2:0]        raw_v, syn_v;
  logic              word_done;
  logic [WORD_W-1:0] word_full;

  assign raw_v = {ser_clk, ser_sel_n, ser_dat};

  spi_cmd_rx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (raw_v),
    .q_out (syn_v)
  );

  spi_cmd_rx_shift u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_s    (syn_v[2]),
    .seln_s    (syn_v[1]),
    .dat_s     (syn_v[0]),
    .blocked   (rst_seq_busy),
    .word_done (word_done),
    .word_full (word_full),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data)
  );

  spi_cmd_rx_mode u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (word_done),
    .bit_imm     (word_full[POS_IMM]),
    .bit_csel    (word_full[POS_CSEL]),
    .bit_rsv     (word_full[POS_RSV]),
    .bit_fill    (word_full[POS_FILL]),
    .pin_immed   (pin_immed),
    .pin_extclk  (pin_extclk),
    .mode_immed  (mode_immed),
    .mode_extclk (mode_extclk),
    .rsvd_err    (rsvd_err)
  );

  assign seq_hold = ~syn_v[1];

  assert_hold_no_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(seq_hold));
endmodule

// File: tb/sim_spi_cmd_rx.sv
module sim_spi_cmd_rx;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;
  localparam int NV = 8;
  // {pin_immed, pin_extclk, word}
  localparam logic [25:0] VEC [NV] = '{
    {2'b00, 16'hA5C3, 4'h3, 4'b0000},
    {2'b00, 16'h1234, 4'hF, 4'b0100},
    {2'b00, 16'hFFFF, 4'h0, 4'b0010},
    {2'b10, 16'h0001, 4'h8, 4'b0000},
    {2'b01, 16'h8000, 4'h7, 4'b0100},
    {2'b00, 16'h4F2C, 4'hA, 4'b1000},
    {2'b00, 16'h0000, 4'h5, 4'b0001},
    {2'b00, 16'h7E7E, 4'hC, 4'b0000}
  };

  logic clk = 0, rst_n = 0;
  logic ser_clk = 0, ser_sel_n = 1, ser_dat = 0;
  logic rst_seq_busy = 0, pin_immed = 0, pin_extclk = 0;
  logic wr_en, mode_immed, mode_extclk, seq_hold, rsvd_err;
  logic [3:0]  wr_addr;
  logic [15:0] wr_data;

  int errors = 0, checks = 0, wr_cnt = 0, wide = 0, cyc = 0;
  logic [3:0]  a_log [4];
  logic [15:0] d_log [4];
  logic wr_prev = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_cmd_rx u0 (.*);

  always @(posedge clk) begin
    if (wr_en) begin
      a_log[wr_cnt % 4] <= wr_addr;
      d_log[wr_cnt % 4] <= wr_data;
      wr_cnt <= wr_cnt + 1;
      if (wr_prev) wide <= wide + 1;
    end
    wr_prev <= wr_en;
    cyc <= cyc + 1;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      errors = errors + 1; checks = checks + 1;
      $display("FAIL watchdog: act=%0d exp<150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    ser_clk = 0; ser_dat = b; wait_clk(HALF);
    ser_clk = 1; wait_clk(HALF);
  endtask

  task automatic open_frame();
    ser_sel_n = 0; wait_clk(HALF);
  endtask

  task automatic close_frame();
    ser_clk = 0; wait_clk(HALF);
    ser_sel_n = 1; wait_clk(2*HALF);
  endtask

  task automatic send_word(input logic [23:0] w);
    for (int i = 23; i >= 0; i--) send_bit(w[i]);
  endtask

  initial begin
    int base;
    logic [23:0] w;
    wait_clk(3);
    chk("R10 wr_en", wr_en, 0);
    chk("R10 mode_immed", mode_immed, 0);
    chk("R10 mode_extclk", mode_extclk, 0);
    chk("R10 rsvd_err", rsvd_err, 0);
    chk("R10 seq_hold", seq_hold, 0);
    rst_n = 1; wait_clk(3);

    // table walk, one word per frame: R1 R2 R6 R9
    for (int v = 0; v < NV; v++) begin
      w = VEC[v][23:0];
      pin_immed = VEC[v][25]; pin_extclk = VEC[v][24];
      base = wr_cnt;
      open_frame();
      chk("R8 seq_hold in frame", seq_hold, 1);
      send_word(w);
      close_frame();
      chk("R2 one write", wr_cnt - base, 1);
      chk("R1 addr", a_log[base % 4], w[7:4]);
      chk("R1 data", d_log[base % 4], w[23:8]);
      chk("R6 immed", mode_immed, w[2] | VEC[v][25]);
      chk("R6 extclk", mode_extclk, w[1] | VEC[v][24]);
      chk("R9 rsvd_err", rsvd_err, w[3] | w[0]);
      chk("R8 seq_hold idle", seq_hold, 0);
    end
    pin_immed = 0; pin_extclk = 0;
    chk("R2 single-cycle pulses", wide, 0);

    // R3 back to back in one frame
    base = wr_cnt;
    open_frame();
    send_word({16'h1111, 4'h1, 4'b0100});
    send_word({16'h2222, 4'h2, 4'b0010});
    close_frame();
    chk("R3 two writes", wr_cnt - base, 2);
    chk("R3 first data", d_log[base % 4], 16'h1111);
    chk("R3 second data", d_log[(base+1) % 4], 16'h2222);
    chk("R3 second addr", a_log[(base+1) % 4], 4'h2);
    chk("R6 latched from last word", {mode_immed, mode_extclk}, 2'b01);

    // R4 partial word, then R5 fresh frame
    base = wr_cnt;
    open_frame();
    for (int i = 0; i < 10; i++) send_bit(1'b1);
    close_frame();
    chk("R4 partial no write", wr_cnt - base, 0);
    open_frame();
    send_word({16'hC0DE, 4'h9, 4'b0000});
    close_frame();
    chk("R5 restart count", wr_cnt - base, 1);
    chk("R5 data after partial", d_log[base % 4], 16'hC0DE);

    // R4 one whole word plus trailing partial
    base = wr_cnt;
    open_frame();
    send_word({16'hBEEF, 4'h6, 4'b0000});
    for (int i = 0; i < 6; i++) send_bit(1'b1);
    close_frame();
    chk("R4 whole plus partial", wr_cnt - base, 1);
    chk("R4 data kept", d_log[base % 4], 16'hBEEF);

    // R11 clock edges with select high
    base = wr_cnt;
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    ser_clk = 0; wait_clk(HALF);
    chk("R11 no write deselected", wr_cnt - base, 0);
    open_frame();
    send_word({16'h0F0F, 4'hB, 4'b0000});
    close_frame();
    chk("R11 one write", wr_cnt - base, 1);
    chk("R11 aligned data", d_log[base % 4], 16'h0F0F);

    // R7 reset sequence blocks input
    base = wr_cnt;
    rst_seq_busy = 1;
    open_frame();
    send_word({16'h5555, 4'h4, 4'b0110});
    close_frame();
    chk("R7 no write", wr_cnt - base, 0);
    chk("R7 modes kept", {mode_immed, mode_extclk}, 2'b00);
    rst_seq_busy = 0; wait_clk(2);

    // R10 reset mid-run
    open_frame();
    send_word({16'h3333, 4'h3, 4'b0110});
    close_frame();
    chk("R6 latch set", {mode_immed, mode_extclk}, 2'b11);
    rst_n = 0; wait_clk(2);
    chk("R10 modes cleared", {mode_immed, mode_extclk}, 2'b00);
    rst_n = 1; wait_clk(2);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule